// File: doc/BRIEF.md
# Dump Boundary Timestamp Scheduler

This block watches the stream of batch timestamps arriving at a correlator accumulation stage and decides where each accumulation period (a dump) opens and closes. Three static settings fix the timing. The batch step is the heap spectrum count times the sample spacing between spectra. The dump interval is that step times the number of batches per dump. A fourth setting gives the number of consecutive batches that make up one processing chunk.

For every accepted batch the block reports the aligned timestamp of the dump the batch belongs to. It also flags the first batch of a dump and the batch at which the previous dump is known to have ended, and gives the ending dump's timestamp. Dump boundaries fall on whole batches, but they need not fall on chunk edges. For that reason the block also reports, for each batch, the run of chunk offsets that belong to the same dump. A downstream kernel can then process only the covered part of a split chunk. Batches whose timestamp is not on the batch grid are rejected and leave all tracking state untouched.

Batches within a chunk are expected to carry consecutive timestamps, one batch step apart. Jumps in time are expected only at chunk edges. The results appear one clock after the batch is presented.

Top module: `dump_sched`

## Requirements
- R1: A batch is rejected with `out_ts_err`=1 when its timestamp is not a multiple of the batch step, or when the batch step, the batches per dump or the batches per chunk setting is zero, or when the dump interval does not fit the timestamp width. A rejected batch raises neither dump marker and leaves the chunk offset, the segment start and the dump history unchanged.
- R2: For an accepted batch, `out_dump_ts` equals floor(ts / interval) × interval, where interval = spectra × spacing × batches_per_dump.
- R3: `out_dump_start` is 1 for the first accepted batch after reset, and for every accepted batch whose dump timestamp differs from that of the previous accepted batch.
- R4: `out_dump_end` is 1 exactly when an accepted batch's dump timestamp differs from that of an earlier accepted batch. In that cycle `out_end_ts` carries the timestamp of the dump that ended, and it holds that value until the next end marker.
- R5: `out_chunk_off` gives the offset within the chunk. It is 0 for the first accepted batch after reset, advances by one per accepted batch, and wraps to 0 after batches_per_chunk − 1.
- R6: `out_seg_first` is the chunk offset at which the current dump's run inside the present chunk began. That is the batch's own offset at a chunk start or a dump start, and otherwise the value carried from the previous accepted batch.
- R7: `out_seg_last` = off + min(batches_per_dump − p, batches_per_chunk − off) − 1. Here off is the batch's chunk offset and p = (ts / step) mod batches_per_dump is its position inside the dump.
- R8: `out_seg_split` is 1 for an accepted batch whose segment does not cover the whole chunk, that is when first ≠ 0 or last ≠ batches_per_chunk − 1.
- R9: All results are registered one cycle after the batch. `out_valid` follows `in_valid` by one cycle. After reset `out_valid`, `out_ts_err`, both dump markers and `out_chunk_off` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spectra_per_heap | input | 16 | Spectra carried by one heap |
| cfg_samples_between | input | 16 | Sample count between consecutive spectra |
| cfg_batches_per_dump | input | 16 | Batches accumulated into one dump |
| cfg_batches_per_chunk | input | 16 | Batches forming one chunk |
| in_valid | input | 1 | A batch timestamp is presented this cycle |
| in_ts | input | 32 | Batch timestamp in samples |
| out_valid | output | 1 | Results below describe the batch of the previous cycle |
| out_ts_err | output | 1 | Batch rejected |
| out_dump_start | output | 1 | Batch opens a new dump |
| out_dump_end | output | 1 | The previous dump has ended |
| out_dump_ts | output | 32 | Aligned timestamp of the batch's dump |
| out_end_ts | output | 32 | Timestamp of the most recently ended dump |
| out_chunk_off | output | 16 | Offset of the batch within its chunk |
| out_seg_first | output | 16 | First chunk offset of the batch's dump run |
| out_seg_last | output | 16 | Last chunk offset of the batch's dump run |
| out_seg_split | output | 1 | The run covers only part of the chunk |

## Verification
The block holds only a small amount of history: the last dump timestamp, a presence flag, the chunk offset counter and the segment start. A wrong value in any of these shows at the ports on the very next accepted batch. A stale dump timestamp yields a missing or spurious start/end pair. A slipped counter shifts `out_chunk_off` and with it both segment bounds. A lost segment start changes `out_seg_first` in the middle of a chunk. The sweep over several dump and chunk lengths puts dump boundaries at every offset inside a chunk. Rejected timestamps and idle cycles are interleaved so that any disturbance of the history by ignored input appears one cycle later.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  localparam int unsigned TS_W   = 32;
  localparam int unsigned CFG_W  = 16;
  localparam int unsigned PROD_W = 2 * CFG_W;
  localparam int unsigned IV_W   = PROD_W + CFG_W;

  typedef logic [TS_W-1:0]  ts_t;
  typedef logic [CFG_W-1:0] cnt_t;

  // Per-batch placement produced by the locator
  typedef struct packed {
    logic err;
    ts_t  dump_ts;
    cnt_t left_in_dump;
  } loc_t;
endpackage

// File: rtl/dsch_divider.sv
// Unrolled restoring divider, one subtract stage per numerator bit.
module dsch_divider #(
  parameter int unsigned NW = 32,
  parameter int unsigned DW = 16
) (
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  logic [DW:0] part [NW+1];
  logic [DW:0] den_x;

  assign den_x   = {1'b0, den};
  assign part[0] = '0;

  for (genvar i = 0; i < NW; i++) begin : g_stage
    logic [DW:0] shifted;
    logic        take;
    assign shifted       = {part[i][DW-1:0], num[NW-1-i]};
    assign take          = (shifted >= den_x);
    assign quo[NW-1-i]   = take;
    assign part[i+1]     = take ? (shifted - den_x) : shifted;
  end

  assign rem = part[NW][DW-1:0];

  always_comb begin
    if (den != '0) begin
      AST_REM_BELOW_DIVISOR: assert (rem < den); // R2
    end
  end
endmodule

// File: rtl/dsch_locate.sv
// Places one batch timestamp on the batch grid and inside its dump.
module dsch_locate
  import dsch_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_spectra_per_heap,
  input  logic [CFG_W-1:0] cfg_samples_between,
  input  logic [CFG_W-1:0] cfg_batches_per_dump,
  input  logic [CFG_W-1:0] cfg_batches_per_chunk,
  input  ts_t              ts,
  output loc_t             loc
);
  logic [PROD_W-1:0] step;
  logic [IV_W-1:0]   interval;
  ts_t               batch_idx;
  logic [PROD_W-1:0] grid_rem;
  ts_t               dump_idx;
  cnt_t              pos;
  logic              cfg_bad;
  logic              iv_overflow;

  assign step     = cfg_spectra_per_heap * cfg_samples_between;
  assign interval = step * cfg_batches_per_dump;

  dsch_divider #(.NW(TS_W), .DW(PROD_W)) u_grid_div (
    .num (ts),
    .den (step),
    .quo (batch_idx),
    .rem (grid_rem)
  );

  dsch_divider #(.NW(TS_W), .DW(CFG_W)) u_dump_div (
    .num (batch_idx),
    .den (cfg_batches_per_dump),
    .quo (dump_idx),
    .rem (pos)
  );

  assign iv_overflow = |interval[IV_W-1:TS_W];
  assign cfg_bad     = (step == '0) | (cfg_batches_per_dump == '0) |
                       (cfg_batches_per_chunk == '0);

  always_comb begin
    loc.err          = cfg_bad | iv_overflow | (grid_rem != '0);
    loc.dump_ts      = dump_idx * interval[TS_W-1:0];
    loc.left_in_dump = cfg_batches_per_dump - pos;
  end
endmodule

// File: rtl/dsch_tracker.sv
// Dump history, chunk offset and segment bookkeeping with registered outputs.
module dsch_tracker
  import dsch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cnt_t  cfg_batches_per_chunk,
  input  logic  in_valid,
  input  loc_t  loc,
  output logic  out_valid,
  output logic  out_ts_err,
  output logic  out_dump_start,
  output logic  out_dump_end,
  output ts_t   out_dump_ts,
  output ts_t   out_end_ts,
  output cnt_t  out_chunk_off,
  output cnt_t  out_seg_first,
  output cnt_t  out_seg_last,
  output logic  out_seg_split
);
  // history state
  logic have_q, have_d;
  ts_t  prev_q, prev_d;
  cnt_t cnt_q, cnt_d;
  cnt_t segf_q, segf_d;

  // output registers
  logic valid_q, valid_d;
  logic err_q, err_d;
  logic start_q, start_d;
  logic end_q, end_d;
  ts_t  dts_q, dts_d;
  ts_t  ets_q, ets_d;
  cnt_t off_q, off_d;
  cnt_t first_q, first_d;
  cnt_t last_q, last_d;
  logic split_q, split_d;

  // combinational intermediates
  cnt_t off, left_chunk, run, seg_first, seg_last;
  logic accept, differs, is_new, wrap;

  always_comb begin
    off        = cnt_q;
    left_chunk = cfg_batches_per_chunk - off;
    run        = (loc.left_in_dump < left_chunk) ? loc.left_in_dump : left_chunk;
    accept     = in_valid & ~loc.err;
    differs    = have_q & (loc.dump_ts != prev_q);
    is_new     = ~have_q | differs;
    seg_first  = (is_new | (off == '0)) ? off : segf_q;
    seg_last   = off + run - CFG_W'(1);
    wrap       = ((off + CFG_W'(1)) >= cfg_batches_per_chunk);

    have_d = have_q | accept;
    prev_d = accept ? loc.dump_ts : prev_q;
    cnt_d  = accept ? (wrap ? '0 : off + CFG_W'(1)) : cnt_q;
    segf_d = accept ? seg_first : segf_q;

    valid_d = in_valid;
    err_d   = in_valid & loc.err;
    start_d = accept & is_new;
    end_d   = accept & differs;
    ets_d   = (accept & differs) ? prev_q : ets_q;
    dts_d   = accept ? loc.dump_ts : '0;
    off_d   = off;
    first_d = accept ? seg_first : '0;
    last_d  = accept ? seg_last : '0;
    split_d = accept & ((seg_first != '0) |
                        (seg_last != cfg_batches_per_chunk - CFG_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      prev_q  <= '0;
      cnt_q   <= '0;
      segf_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      dts_q   <= '0;
      ets_q   <= '0;
      off_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      split_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      start_q <= start_d;
      end_q   <= end_d;
      ets_q   <= ets_d;
      if (accept) begin
        have_q <= have_d;
        prev_q <= prev_d;
        cnt_q  <= cnt_d;
        segf_q <= segf_d;
      end
      if (in_valid) begin
        dts_q   <= dts_d;
        off_q   <= off_d;
        first_q <= first_d;
        last_q  <= last_d;
        split_q <= split_d;
      end
    end
  end

  assign out_valid      = valid_q;
  assign out_ts_err     = err_q;
  assign out_dump_start = start_q;
  assign out_dump_end   = end_q;
  assign out_dump_ts    = dts_q;
  assign out_end_ts     = ets_q;
  assign out_chunk_off  = off_q;
  assign out_seg_first  = first_q;
  assign out_seg_last   = last_q;
  assign out_seg_split  = split_q;

  AST_REJECT_NO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    out_ts_err |-> (!out_dump_start && !out_dump_end)); // R1
  AST_END_OPENS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_dump_end |-> out_dump_start); // R4
  AST_END_TS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    out_dump_end |-> (out_end_ts != out_dump_ts)); // R4
  AST_END_TS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_d |=> $stable(out_end_ts)); // R4
  AST_OFF_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ts_err && $stable(cfg_batches_per_chunk))
      |-> (out_chunk_off < cfg_batches_per_chunk)); // R5
  AST_SEG_BRACKETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ts_err)
      |-> (out_seg_first <= out_chunk_off && out_chunk_off <= out_seg_last)); // R6
  AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dump_start || out_ts_err) |-> out_valid); // R9
endmodule

// File: rtl/dump_sched.sv
module dump_sched
  import dsch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_spectra_per_heap,
  input  logic [CFG_W-1:0] cfg_samples_between,
  input  logic [CFG_W-1:0] cfg_batches_per_dump,
  input  logic [CFG_W-1:0] cfg_batches_per_chunk,
  input  logic             in_valid,
  input  logic [TS_W-1:0]  in_ts,
  output logic             out_valid,
  output logic             out_ts_err,
  output logic             out_dump_start,
  output logic             out_dump_end,
  output logic [TS_W-1:0]  out_dump_ts,
  output logic [TS_W-1:0]  out_end_ts,
  output logic [CFG_W-1:0] out_chunk_off,
  output logic [CFG_W-1:0] out_seg_first,
  output logic [CFG_W-1:0] out_seg_last,
  output logic             out_seg_split
);
  loc_t loc;

  dsch_locate u_locate (
    .cfg_spectra_per_heap  (cfg_spectra_per_heap),
    .cfg_samples_between   (cfg_samples_between),
    .cfg_batches_per_dump  (cfg_batches_per_dump),
    .cfg_batches_per_chunk (cfg_batches_per_chunk),
    .ts                    (in_ts),
    .loc                   (loc)
  );

  dsch_tracker u_tracker (
    .clk                   (clk),
    .rst_n                 (rst_n),
    .cfg_batches_per_chunk (cfg_batches_per_chunk),
    .in_valid              (in_valid),
    .loc                   (loc),
    .out_valid             (out_valid),
    .out_ts_err            (out_ts_err),
    .out_dump_start        (out_dump_start),
    .out_dump_end          (out_dump_end),
    .out_dump_ts           (out_dump_ts),
    .out_end_ts            (out_end_ts),
    .out_chunk_off         (out_chunk_off),
    .out_seg_first         (out_seg_first),
    .out_seg_last          (out_seg_last),
    .out_seg_split         (out_seg_split)
  );
endmodule

// File: tb/dump_sched_test.sv
module dump_sched_test;
  localparam int TCLK = 10;
  localparam int SPH  = 2;
  localparam int SBS  = 3;
  localparam int STEP = SPH * SBS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_sph, cfg_sbs, cfg_bpd, cfg_bpc;
  logic        in_valid;
  logic [31:0] in_ts;
  logic        out_valid, out_ts_err, out_dump_start, out_dump_end, out_seg_split;
  logic [31:0] out_dump_ts, out_end_ts;
  logic [15:0] out_chunk_off, out_seg_first, out_seg_last;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench reference state
  bit m_have;
  int m_prev, m_end_ts, m_cnt, m_segf, m_bpd, m_bpc;

  always #(TCLK/2) clk = ~clk;

  dump_sched uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_spectra_per_heap(cfg_sph), .cfg_samples_between(cfg_sbs),
    .cfg_batches_per_dump(cfg_bpd), .cfg_batches_per_chunk(cfg_bpc),
    .in_valid(in_valid), .in_ts(in_ts),
    .out_valid(out_valid), .out_ts_err(out_ts_err),
    .out_dump_start(out_dump_start), .out_dump_end(out_dump_end),
    .out_dump_ts(out_dump_ts), .out_end_ts(out_end_ts),
    .out_chunk_off(out_chunk_off), .out_seg_first(out_seg_first),
    .out_seg_last(out_seg_last), .out_seg_split(out_seg_split)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int bpd, input int bpc);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_ts = '0;
    cfg_sph = 16'(SPH); cfg_sbs = 16'(SBS);
    cfg_bpd = 16'(bpd); cfg_bpc = 16'(bpc);
    m_have = 0; m_prev = 0; m_end_ts = 0; m_cnt = 0; m_segf = 0;
    m_bpd = bpd; m_bpc = bpc;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "valid after reset", out_valid, 0);
    chk(out_dump_start == 1'b0 && out_dump_end == 1'b0, "R9", "markers after reset",
        out_dump_start, 0);
    chk(out_chunk_off == 16'd0, "R9", "offset after reset", out_chunk_off, 0);
  endtask

  task automatic send(input bit v, input int ts);
    bit err, sod, eod;
    int iv, dts, p, off, first, last, rd, rc;
    iv  = STEP * m_bpd;
    err = (ts % STEP) != 0 || m_bpd == 0 || m_bpc == 0;
    @(negedge clk);
    in_valid = v; in_ts = 32'(ts);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid == v, "R9", "valid delay", out_valid, v);
    if (!v) begin
      chk(!out_dump_start && !out_dump_end && !out_ts_err, "R9", "idle pulses",
          out_dump_start, 0);
    end else if (err) begin
      chk(out_ts_err == 1'b1, "R1", "reject flag", out_ts_err, 1);
      chk(!out_dump_start && !out_dump_end, "R1", "reject markers",
          {out_dump_start, out_dump_end}, 0);
    end else begin
      dts   = (ts / iv) * iv;
      p     = (ts / STEP) % m_bpd;
      sod   = !m_have || dts != m_prev;
      eod   = m_have && dts != m_prev;
      off   = m_cnt;
      first = (sod || off == 0) ? off : m_segf;
      rd    = m_bpd - p;
      rc    = m_bpc - off;
      last  = off + ((rd < rc) ? rd : rc) - 1;
      if (eod) m_end_ts = m_prev;
      chk(out_ts_err == 1'b0, "R1", "accept flag", out_ts_err, 0);
      chk(out_dump_ts == 32'(dts), "R2", "dump ts", out_dump_ts, dts);
      chk(out_dump_start == sod, "R3", "dump start", out_dump_start, sod);
      chk(out_dump_end == eod, "R4", "dump end", out_dump_end, eod);
      chk(out_end_ts == 32'(m_end_ts), "R4", "end ts", out_end_ts, m_end_ts);
      chk(out_chunk_off == 16'(off), "R5", "chunk offset", out_chunk_off, off);
      chk(out_seg_first == 16'(first), "R6", "segment first", out_seg_first, first);
      chk(out_seg_last == 16'(last), "R7", "segment last", out_seg_last, last);
      chk(out_seg_split == (first != 0 || last != m_bpc - 1), "R8", "split flag",
          out_seg_split, (first != 0 || last != m_bpc - 1));
      m_have = 1; m_prev = dts; m_segf = first;
      m_cnt  = (off + 1 >= m_bpc) ? 0 : off + 1;
    end
  endtask

  task automatic run_cfg(input int bpd, input int bpc);
    int ts;
    do_reset(bpd, bpc);
    ts = STEP * (7 + bpd * bpc);
    for (int i = 0; i < bpc * 5; i++) begin
      if (i % 5 == 3) send(1, ts + 1);  // R1 off-grid timestamp
      if (i % 7 == 4) send(0, 0);
      send(1, ts);
      ts += STEP;
    end
    ts += STEP * (bpd * 3 + 1);          // jump at a chunk edge
    for (int i = 0; i < bpc * 3; i++) begin
      if (i % 4 == 2) send(1, ts + 2);
      send(1, ts);
      ts += STEP;
    end
  endtask

  initial begin
    in_valid = 1'b0; in_ts = '0;
    cfg_sph = 16'(SPH); cfg_sbs = 16'(SBS); cfg_bpd = 16'd1; cfg_bpc = 16'd1;
    for (int d = 0; d < 5; d++) begin
      for (int c = 1; c <= 5; c++) begin
        run_cfg((d == 4) ? 7 : d + 1, c);
      end
    end
    // R1 zero batches-per-dump rejects even grid-aligned stamps
    do_reset(0, 3);
    send(1, 60);
    // R1 state untouched: a following good config batch starts at offset 0
    do_reset(2, 3);
    send(1, 61);
    send(1, 60);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule